// File: doc/BRIEF.md
# Packet-Level Cell Reassembly Merger

This block sits on the output side of a cell switch. It lets several incoming virtual circuits share one outgoing circuit while keeping the cells of different packets apart. Each cell from the fabric arrives in one slot. It carries an input port number, an incoming VC identifier, a last-cell flag and an opaque payload word. Cells are kept in a reassembly queue chosen by the pair (port, VCI) until the last cell of their packet arrives. The finished packet is then moved, one cell per clock and without a break, onto an output queue. During that move each cell's identifier is replaced by the outgoing VCI held in a translation table.

All reassembly queues and the output queue are linked lists in one shared pool of cell slots. When no slot is free, the arriving cell is dropped and the partial packet on that circuit is marked damaged. Its stored cells are released when its last cell arrives, and nothing of that packet reaches the output. Several completed packets that wait at the same time are served in round-robin order over queue numbers. The input never stalls. The output uses a valid/ready handshake.

Top module: `cell_merger`

## Requirements
- R1: After reset no cell is offered at the output (`out_valid` low) and every slot of the pool is free.
- R2: No cell of a packet is offered at the output before that packet's last cell (`cell_last` = 1) has been accepted.
- R3: The cells of one packet leave consecutively and in arrival order, with no cell of another packet between them.
- R4: Each departing cell carries the outgoing VCI stored in table entry `{port, vci}` of its queue, and different queues may map to the same outgoing VCI.
- R5: Cells with equal VCI but different input ports go to separate queues and never mix.
- R6: When several completed packets are waiting, the next one served is from the first waiting queue above the last served queue number, wrapping at the top.
- R7: A cell that finds no free slot is dropped. Later cells of that packet are discarded. At the packet's last cell the stored part is released and nothing of it is output. The next packet on that circuit is handled normally.
- R8: While `out_valid` is high and `out_ready` is low, `out_data`, `out_vci` and `out_last` hold their values.
- R9: `out_last` is 1 exactly on the final cell of each packet.
- R10: Slots released by output or discard become available again, so one packet filling the whole pool (DEPTH cells) is accepted after earlier overflows.
- R11: A write through the table port (`map_we`) changes the outgoing VCI used by packets moved afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cell_valid | input | 1 | A cell is present this slot |
| cell_port | input | PORT_W | Input port number tag |
| cell_vci | input | VCI_W | Incoming VC identifier |
| cell_last | input | 1 | Last cell of its packet |
| cell_data | input | DATA_W | Opaque cell payload |
| map_we | input | 1 | Translation table write enable |
| map_addr | input | PORT_W+VCI_W | Table entry `{port, vci}` |
| map_vci | input | OVCI_W | Outgoing VCI to store |
| out_valid | output | 1 | Output cell available |
| out_ready | input | 1 | Consumer takes the output cell |
| out_vci | output | OVCI_W | Rewritten outgoing VCI |
| out_last | output | 1 | Last cell of its packet |
| out_data | output | DATA_W | Cell payload |

## Verification
A broken link pointer or slot state shows up at the output within a packet time. The result is a payload out of order, a cell from a foreign queue inside a burst, or a missing final-cell flag. A leaked slot only shows later, when a packet of full pool size no longer fits after an overflow. That packet then comes out short or damaged. Wrong queue bookkeeping after a discard shows up as debris from the dropped packet ahead of the next good one on the same circuit.

// File: rtl/merge_pkg.sv
// Shared types of the cell merger.
package merge_pkg;
    // Life cycle of one pool slot.
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,   // on no list
        SLOT_PART = 2'd1,   // belongs to an unfinished packet
        SLOT_DONE = 2'd2,   // belongs to a finished packet awaiting transfer
        SLOT_OUT  = 2'd3    // linked on the output queue
    } slot_st_t;
endpackage

// File: rtl/rr_arbiter.sv
// Round-robin selector over N request lines. The search starts just above
// the last granted index and wraps. Assumes N is a power of two.
module rr_arbiter #(
    parameter int N = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    input  logic                 adv,
    output logic                 gnt_valid,
    output logic [$clog2(N)-1:0] gnt_idx
);
    localparam int IW = $clog2(N);

    logic [IW-1:0] last_q;
    logic [IW-1:0] cand;

    // Find the first request after the last grant.
    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = last_q;
        cand      = last_q;
        for (int i = 1; i <= N; i++) begin
            cand = last_q + IW'(i);
            if (!gnt_valid && req[cand]) begin
                gnt_valid = 1'b1;
                gnt_idx   = cand;
            end
        end
    end

    // Remember the granted index once the grant is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)                 last_q <= IW'(N - 1);
        else if (adv && gnt_valid)  last_q <= gnt_idx;
    end

    // R6: a grant only goes to a requesting line.
    a_r6_grant_req: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> req[gnt_idx]);
endmodule

// File: rtl/slot_alloc.sv
// Picks the lowest-numbered free pool slot and counts the free slots.
module slot_alloc #(
    parameter int DEPTH = 16
) (
    input  logic [DEPTH-1:0]           free_vec,
    output logic                       any_free,
    output logic [$clog2(DEPTH)-1:0]   free_idx,
    output logic [$clog2(DEPTH+1)-1:0] free_cnt
);
    localparam int AW = $clog2(DEPTH);

    // Priority pick, lowest index wins.
    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (free_vec[i]) free_idx = AW'(i);
        end
        any_free = |free_vec;
        free_cnt = $bits(free_cnt)'($countones(free_vec));
    end
endmodule

// File: rtl/vci_xlate.sv
// Translation table: one outgoing VCI per reassembly queue, written
// synchronously and read combinationally. Entries reset to zero.
module vci_xlate #(
    parameter int QID_W  = 5,
    parameter int OVCI_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [QID_W-1:0]  waddr,
    input  logic [OVCI_W-1:0] wdata,
    input  logic [QID_W-1:0]  raddr,
    output logic [OVCI_W-1:0] rdata
);
    localparam int NQ = 1 << QID_W;

    logic [OVCI_W-1:0] tbl [NQ];

    // Table write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NQ; i++) tbl[i] <= '0;
        end else if (we) begin
            tbl[waddr] <= wdata;
        end
    end

    // Lookup for the transfer engine.
    assign rdata = tbl[raddr];
endmodule

// File: rtl/cell_merger.sv
// Output-side cell merger. Cells are kept per (port, vci) queue in a
// shared linked-list pool until end of packet. Finished packets move one
// cell per clock onto the output list with VCI rewrite, one packet at a
// time, chosen round-robin. Assumes 2**(PORT_W+VCI_W) is a power of two
// (always true) and DEPTH >= 2. The input never back-pressures.
module cell_merger #(
    parameter int PORT_W = 2,
    parameter int VCI_W  = 3,
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    parameter int OVCI_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cell_valid,
    input  logic [PORT_W-1:0]       cell_port,
    input  logic [VCI_W-1:0]        cell_vci,
    input  logic                    cell_last,
    input  logic [DATA_W-1:0]       cell_data,
    input  logic                    map_we,
    input  logic [PORT_W+VCI_W-1:0] map_addr,
    input  logic [OVCI_W-1:0]       map_vci,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [OVCI_W-1:0]       out_vci,
    output logic                    out_last,
    output logic [DATA_W-1:0]       out_data
);
    import merge_pkg::*;

    localparam int QID_W = PORT_W + VCI_W;
    localparam int NQ    = 1 << QID_W;
    localparam int AW    = $clog2(DEPTH);
    localparam int LW    = $clog2(DEPTH + 1);

    // Pool storage.
    logic [DATA_W-1:0] pay_mem  [DEPTH];
    logic              last_mem [DEPTH];
    logic [QID_W-1:0]  own_mem  [DEPTH];
    logic [OVCI_W-1:0] ovci_mem [DEPTH];
    logic [AW-1:0]     nxt      [DEPTH];
    slot_st_t          st_mem   [DEPTH], st_n [DEPTH];

    // Reassembly queue state.
    logic [AW-1:0] q_head [NQ], qh_n [NQ];
    logic [AW-1:0] q_tail [NQ], qt_n [NQ];
    logic [AW-1:0] q_dtail[NQ], qd_n [NQ];
    logic [LW-1:0] q_len  [NQ], ql_n [NQ];
    logic [LW-1:0] q_part [NQ], qp_n [NQ];
    logic          q_bad  [NQ], qb_n [NQ];

    // Output list and transfer engine.
    logic [AW-1:0] o_head, o_tail, oh_n, ot_n;
    logic [LW-1:0] o_len, ol_n;
    logic          x_busy;
    logic [QID_W-1:0] x_q;

    logic [QID_W-1:0]  in_q;
    logic [DEPTH-1:0]  free_vec;
    logic              any_free;
    logic [AW-1:0]     free_idx;
    logic [LW-1:0]     free_cnt;
    logic              store, discard, mark_bad, pop, arr_link;
    logic [AW-1:0]     mv_cell;
    logic              mv_last;
    logic [LW-1:0]     in_len_after;
    logic [NQ-1:0]     req;
    logic              gnt_valid;
    logic [QID_W-1:0]  gnt_idx;
    logic [OVCI_W-1:0] tbl_rd;

    assign in_q = {cell_port, cell_vci};

    // Free-slot vector for the allocator.
    always_comb begin
        for (int s = 0; s < DEPTH; s++) free_vec[s] = (st_mem[s] == SLOT_FREE);
    end

    slot_alloc #(.DEPTH(DEPTH)) i_alloc (
        .free_vec (free_vec),
        .any_free (any_free),
        .free_idx (free_idx),
        .free_cnt (free_cnt)
    );

    // Queues with a finished packet at their head ask for transfer.
    always_comb begin
        for (int q = 0; q < NQ; q++)
            req[q] = (q_len[q] != '0) && (st_mem[q_head[q]] == SLOT_DONE);
    end

    rr_arbiter #(.N(NQ)) i_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .adv       (!x_busy),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    vci_xlate #(.QID_W(QID_W), .OVCI_W(OVCI_W)) i_xlate (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (map_we),
        .waddr (map_addr),
        .wdata (map_vci),
        .raddr (x_q),
        .rdata (tbl_rd)
    );

    // Per-cycle events on the input, output and transfer path.
    always_comb begin
        mv_cell      = q_head[x_q];
        mv_last      = last_mem[mv_cell];
        pop          = out_valid && out_ready;
        store        = cell_valid && !q_bad[in_q] && any_free;
        mark_bad     = cell_valid && !q_bad[in_q] && !any_free && !cell_last;
        discard      = cell_valid && cell_last && (q_bad[in_q] || !any_free);
        in_len_after = q_len[in_q] - ((x_busy && x_q == in_q) ? LW'(1) : LW'(0));
        arr_link     = store && (in_len_after != '0);
    end

    // Next state of queues, slot states and output list.
    always_comb begin
        qh_n = q_head; qt_n = q_tail; qd_n = q_dtail;
        ql_n = q_len;  qp_n = q_part; qb_n = q_bad;
        st_n = st_mem;
        oh_n = o_head; ot_n = o_tail;
        ol_n = o_len + (x_busy ? LW'(1) : LW'(0)) - (pop ? LW'(1) : LW'(0));
        // Transfer: unlink the head cell of the granted queue.
        if (x_busy) begin
            qh_n[x_q]     = nxt[mv_cell];
            ql_n[x_q]     = q_len[x_q] - LW'(1);
            st_n[mv_cell] = SLOT_OUT;
        end
        // Output: release the popped cell.
        if (pop) begin
            st_n[o_head] = SLOT_FREE;
            oh_n         = nxt[o_head];
        end
        // Output: append the moved cell.
        if (x_busy) begin
            if (o_len == '0 || (pop && o_len == LW'(1))) oh_n = mv_cell;
            ot_n = mv_cell;
        end
        // Arrival into a free slot.
        if (store) begin
            st_n[free_idx] = cell_last ? SLOT_DONE : SLOT_PART;
            if (in_len_after == '0) qh_n[in_q] = free_idx;
            qt_n[in_q] = free_idx;
            ql_n[in_q] = in_len_after + LW'(1);
            if (cell_last) begin
                qp_n[in_q] = '0;
                qd_n[in_q] = free_idx;
            end else begin
                qp_n[in_q] = q_part[in_q] + LW'(1);
            end
        end
        if (mark_bad) qb_n[in_q] = 1'b1;
        // Drop the stored part of a damaged packet.
        if (discard) begin
            ql_n[in_q] = in_len_after - q_part[in_q];
            qp_n[in_q] = '0;
            qt_n[in_q] = q_dtail[in_q];
            qb_n[in_q] = 1'b0;
        end
        // Finish or drop all partial slots of this queue.
        if ((store && cell_last) || discard) begin
            for (int s = 0; s < DEPTH; s++) begin
                if (st_mem[s] == SLOT_PART && own_mem[s] == in_q)
                    st_n[s] = discard ? SLOT_FREE : SLOT_DONE;
            end
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) st_mem[s] <= SLOT_FREE;
            for (int q = 0; q < NQ; q++) begin
                q_head[q] <= '0; q_tail[q] <= '0; q_dtail[q] <= '0;
                q_len[q]  <= '0; q_part[q] <= '0; q_bad[q]   <= 1'b0;
            end
            o_head <= '0; o_tail <= '0; o_len <= '0;
            x_busy <= 1'b0; x_q <= '0;
        end else begin
            st_mem <= st_n;
            q_head <= qh_n; q_tail <= qt_n; q_dtail <= qd_n;
            q_len  <= ql_n; q_part <= qp_n; q_bad   <= qb_n;
            o_head <= oh_n; o_tail <= ot_n; o_len   <= ol_n;
            if (x_busy) begin
                if (mv_last) x_busy <= 1'b0;
            end else if (gnt_valid) begin
                x_busy <= 1'b1;
                x_q    <= gnt_idx;
            end
        end
    end

    // Slot contents and links; no reset needed.
    always_ff @(posedge clk) begin
        if (store) begin
            pay_mem[free_idx]  <= cell_data;
            last_mem[free_idx] <= cell_last;
            own_mem[free_idx]  <= in_q;
        end
        if (arr_link) nxt[q_tail[in_q]] <= free_idx;
        if (x_busy) begin
            ovci_mem[mv_cell] <= tbl_rd;
            if (o_len != '0) nxt[o_tail] <= mv_cell;
        end
    end

    // Output view of the head slot.
    assign out_valid = (o_len != '0);
    assign out_data  = pay_mem[o_head];
    assign out_vci   = ovci_mem[o_head];
    assign out_last  = last_mem[o_head];

    // R2: only transferred slots are ever shown at the output.
    a_r2_out_head_moved: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> st_mem[o_head] == SLOT_OUT);
    // R3: the transfer engine only moves finished cells of its own queue.
    a_r3_burst_owner: assert property (@(posedge clk) disable iff (!rst_n)
        x_busy |-> (st_mem[mv_cell] == SLOT_DONE && own_mem[mv_cell] == x_q));
    // R7: a cell on a damaged circuit takes no slot.
    a_r7_bad_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_valid && q_bad[in_q]) |=> free_cnt >= $past(free_cnt));
    // R8: an offered cell holds still until taken.
    a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                       $stable(out_vci) && $stable(out_last)));
endmodule

// File: tb/test_cell_merger.sv
`timescale 1ns/1ps
module test_cell_merger;
    localparam int PORT_W = 2, VCI_W = 3, DEPTH = 16, DATA_W = 32, OVCI_W = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cell_valid = 1'b0, cell_last = 1'b0;
    logic [PORT_W-1:0] cell_port = '0;
    logic [VCI_W-1:0]  cell_vci = '0;
    logic [DATA_W-1:0] cell_data = '0;
    logic map_we = 1'b0;
    logic [PORT_W+VCI_W-1:0] map_addr = '0;
    logic [OVCI_W-1:0] map_vci = '0;
    logic out_valid, out_ready = 1'b0, out_last;
    logic [OVCI_W-1:0] out_vci;
    logic [DATA_W-1:0] out_data;

    int n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    cell_merger i_cell_merger (
        .clk(clk), .rst_n(rst_n), .cell_valid(cell_valid), .cell_port(cell_port),
        .cell_vci(cell_vci), .cell_last(cell_last), .cell_data(cell_data),
        .map_we(map_we), .map_addr(map_addr), .map_vci(map_vci),
        .out_valid(out_valid), .out_ready(out_ready), .out_vci(out_vci),
        .out_last(out_last), .out_data(out_data));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic send(input int port, input int vci, input bit last, input int data);
        cell_valid = 1'b1; cell_port = PORT_W'(port); cell_vci = VCI_W'(vci);
        cell_last = last; cell_data = DATA_W'(data);
        @(negedge clk);
        cell_valid = 1'b0; cell_last = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_map(input int port, input int vci, input int ovci);
        map_we = 1'b1; map_addr = {PORT_W'(port), VCI_W'(vci)}; map_vci = OVCI_W'(ovci);
        @(negedge clk);
        map_we = 1'b0;
    endtask

    task automatic get_cell(input int ovci, input bit last, input int data, input string req);
        int waited = 0;
        while (!out_valid && waited < 60) begin
            @(negedge clk);
            waited++;
        end
        chk(out_valid, req, out_valid, 1);
        chk(out_data == DATA_W'(data), req, out_data, data);
        chk(out_vci == OVCI_W'(ovci), {req, " vci"}, out_vci, ovci);
        chk(out_last == last, {req, " last"}, out_last, last);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic expect_empty(input string req);
        idle(6);
        chk(!out_valid, req, out_valid, 0);
    endtask

    task automatic t_reset;
        chk(!out_valid, "R1 reset out_valid", out_valid, 0);
    endtask

    // R2 held until last cell, then R3/R4/R9 order, rewrite and flag.
    task automatic t_no_cut;
        set_map(0, 1, 8'h21);
        send(0, 1, 0, 32'h100); send(0, 1, 0, 32'h101); send(0, 1, 0, 32'h102);
        idle(10);
        chk(!out_valid, "R2 partial packet held", out_valid, 0);
        send(0, 1, 1, 32'h103);
        for (int i = 0; i < 4; i++) get_cell(8'h21, i == 3, 32'h100 + i, "R3 R9 in-order burst");
        expect_empty("R3 nothing extra");
    endtask

    // R5 same vci on two ports, R4 both merged on one outgoing VCI.
    task automatic t_merge;
        set_map(1, 2, 8'h55); set_map(2, 2, 8'h55);
        send(1, 2, 0, 32'h10); send(2, 2, 0, 32'h20);
        send(1, 2, 0, 32'h11); send(2, 2, 1, 32'h21);
        send(1, 2, 1, 32'h12);
        get_cell(8'h55, 0, 32'h20, "R5 port2 first"); get_cell(8'h55, 1, 32'h21, "R4 merged");
        for (int i = 0; i < 3; i++) get_cell(8'h55, i == 2, 32'h10 + i, "R3 R5 port1 contiguous");
        expect_empty("R5 no leftovers");
    endtask

    // R6 round-robin after queue 2: queue 3 before queue 0.
    task automatic t_rr;
        set_map(0, 0, 8'hA0); set_map(0, 2, 8'hA2); set_map(0, 3, 8'hA3);
        send(0, 2, 0, 32'h200); send(0, 2, 0, 32'h201); send(0, 2, 1, 32'h202);
        send(0, 0, 1, 32'h300); send(0, 3, 1, 32'h400);
        for (int i = 0; i < 3; i++) get_cell(8'hA2, i == 2, 32'h200 + i, "R6 first packet");
        get_cell(8'hA3, 1, 32'h400, "R6 round-robin next");
        get_cell(8'hA0, 1, 32'h300, "R6 round-robin wrap");
    endtask

    // R8 hold while not ready.
    task automatic t_hold;
        logic [DATA_W-1:0] d0;
        send(0, 1, 0, 32'h501); send(0, 1, 1, 32'h502);
        idle(6);
        d0 = out_data;
        idle(4);
        chk(out_valid && out_data == d0, "R8 held while stalled", out_data, d0);
        get_cell(8'h21, 0, 32'h501, "R8 first"); get_cell(8'h21, 1, 32'h502, "R8 second");
    endtask

    // R7 overflow drop and discard, then recovery.
    task automatic t_overflow;
        set_map(3, 0, 8'h30); set_map(3, 1, 8'h31);
        for (int i = 0; i < DEPTH - 1; i++) send(3, 0, 0, 32'h700 + i);
        send(3, 1, 1, 32'h7C0);
        idle(4);
        send(3, 0, 0, 32'h7EE);
        get_cell(8'h31, 1, 32'h7C0, "R7 complete packet survives");
        send(3, 0, 0, 32'h7EF);
        send(3, 0, 1, 32'h7F0);
        expect_empty("R7 damaged packet discarded");
        send(3, 0, 1, 32'h7A5);
        get_cell(8'h30, 1, 32'h7A5, "R7 next packet normal");
        expect_empty("R7 no debris");
    endtask

    // R10 full-pool packet after reclaim.
    task automatic t_full;
        for (int i = 0; i < DEPTH; i++) send(3, 0, i == DEPTH - 1, 32'h900 + i);
        for (int i = 0; i < DEPTH; i++) get_cell(8'h30, i == DEPTH - 1, 32'h900 + i, "R10 full pool packet");
        expect_empty("R10 drained");
    endtask

    // R11 table rewrite takes effect.
    task automatic t_remap;
        set_map(0, 1, 8'hC7);
        send(0, 1, 1, 32'hB00);
        get_cell(8'hC7, 1, 32'hB00, "R11 new mapping");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_cut();
        t_merge();
        t_rr();
        t_hold();
        t_overflow();
        t_full();
        t_remap();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule